// File: doc/BRIEF.md
# Dual-Channel Serial ADC Host Controller

This block drives a two-input serial successive-approximation converter from a single system clock. It produces an active-low chip select and a serial clock derived from the system clock by a programmable divider. For each conversion it shifts an 8-bit control word out on the converter's data input and gathers the 10-bit result from the converter's data output. Every conversion lasts exactly 16 serial-clock periods.

A client asks for a conversion with a valid/ready request that carries a one-bit channel number (0 for the first input, 1 for the second). The converter applies the address it receives during one conversion to the conversion after it. The controller therefore keeps a one-deep channel pipeline and labels each result with the channel that the converter actually sampled. The first result after reset is from the first input. If a new request is waiting when a conversion ends, the next conversion starts at once with chip select still low (back-to-back). Otherwise chip select returns high and the serial clock parks high.

Top module: `dual_adc_host`

## Requirements
- R1: While reset is held and just after it, csN=1, sclk=1, din=0, resValid=0 and reqReady=1.
- R2: sclk stays high whenever csN is high. After csN falls, sclk stays high for at least DIV_HALF system cycles before it falls for the first time. Inside a frame, every low half and every high half of sclk lasts exactly DIV_HALF system cycles.
- R3: Each frame contains a whole multiple of 16 rising sclk edges. csN rises only after the last high half of a conversion has completed, with sclk high.
- R4: din changes only while sclk is low. During clocks 1 to 8 of a conversion, din carries the control word MSB first. Bit 3 of the word is the requested channel (0 selects the first input, 1 the second). Every other bit is 0, so bit 4 is never 1. Outside those eight clocks din is 0.
- R5: The result is the 10 dout values sampled on rising sclk edges 5 to 14 of the conversion, with the first sample as the MSB. Values present on the other six rising edges have no effect on the result.
- R6: resChan carries the channel requested for the conversion before the one that produced the result. The first result after reset carries channel 0.
- R7: resValid is a one-cycle pulse. It rises DIV_HALF system cycles after the 16th rising sclk edge of the conversion.
- R8: reqReady is high while idle and in the last system cycle of a conversion. A request accepted in that last cycle starts the next conversion with csN kept low, so back-to-back results arrive every 32*DIV_HALF system cycles. A request accepted while idle drives csN low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Conversion request valid |
| reqChan | input | 1 | Requested channel (0 first input, 1 second input) |
| reqReady | output | 1 | Request accepted in this cycle when reqValid is high |
| csN | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to converter, idles high |
| din | output | 1 | Control word bit to converter |
| dout | input | 1 | Result bit from converter |
| resValid | output | 1 | One-cycle pulse, result available |
| resData | output | 10 | Conversion result, straight binary |
| resChan | output | 1 | Channel the result was sampled from |

## Verification
The bench includes a behavioural converter that drives 1s on the six non-result clocks. A controller that captures one clock early or late, or that shifts in those extra bits, then returns visibly wrong codes, including all-ones and all-zeros values. The bench alternates channels across single frames and back-to-back bursts. A design that tags results with the current request instead of the previous one, or that loses the address across an idle gap, reports the wrong resChan. The bench also measures each half period, the lead time before the first falling edge, the number of edges per frame and the spacing of back-to-back results. These measurements catch a miscounted divider, a frame closed after fewer than 16 edges, and an idle cycle inserted between chained conversions.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LEAD,
    PH_LOW,
    PH_HIGH
  } adcqPhase_t;

  typedef struct packed {
    logic load;     // request accepted: latch channel, new control word
    logic fall;     // sclk falls at this edge: present next din bit
    logic capture;  // sclk rises at this edge on a result clock: take dout
    logic emit;     // conversion complete at this edge: publish result
  } adcqStrobe_t;

endpackage

// File: rtl/adcq_ctrl.sv
module adcq_ctrl
  import adcq_pkg::*;
#(
  parameter int DIV_HALF  = 25,
  parameter int CONV_CLKS = 16,
  parameter int RES_FIRST = 5,
  parameter int RES_BITS  = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        csN,
  output logic        sclk,
  output adcqStrobe_t stb
);

  localparam int DIV_W   = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int IDX_W   = $clog2(CONV_CLKS);
  localparam int CAP_LO  = RES_FIRST - 1;
  localparam int CAP_HI  = RES_FIRST + RES_BITS - 2;

  adcqPhase_t        phase, nxtPhase;
  logic [DIV_W-1:0]  divCnt;
  logic [IDX_W-1:0]  clkIdx;
  logic              halfDone, lastClk, accept, onResClk;

  assign halfDone = (divCnt == DIV_W'(DIV_HALF - 1));
  assign lastClk  = (clkIdx == IDX_W'(CONV_CLKS - 1));
  assign onResClk = (clkIdx >= IDX_W'(CAP_LO)) && (clkIdx <= IDX_W'(CAP_HI));
  assign reqReady = (phase == PH_IDLE) || (phase == PH_HIGH && halfDone && lastClk);
  assign accept   = reqValid && reqReady;

  always_comb begin
    nxtPhase = phase;
    unique case (phase)
      PH_IDLE: if (accept) nxtPhase = PH_LEAD;
      PH_LEAD: if (halfDone) nxtPhase = PH_LOW;
      PH_LOW:  if (halfDone) nxtPhase = PH_HIGH;
      PH_HIGH: begin
        if (halfDone) begin
          if (!lastClk)    nxtPhase = PH_LOW;
          else if (accept) nxtPhase = PH_LOW;
          else             nxtPhase = PH_IDLE;
        end
      end
      default: nxtPhase = PH_IDLE;
    endcase
  end

  always_comb begin
    stb.load    = accept;
    stb.fall    = (nxtPhase == PH_LOW) && (phase != PH_LOW);
    stb.capture = (phase == PH_LOW) && halfDone && onResClk;
    stb.emit    = (phase == PH_HIGH) && halfDone && lastClk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      divCnt <= '0;
      clkIdx <= '0;
      csN    <= 1'b1;
      sclk   <= 1'b1;
    end else begin
      phase <= nxtPhase;
      csN   <= (nxtPhase == PH_IDLE);
      sclk  <= (nxtPhase != PH_LOW);
      if (nxtPhase != phase || phase == PH_IDLE) divCnt <= '0;
      else                                       divCnt <= divCnt + 1'b1;
      if (phase == PH_IDLE)                      clkIdx <= '0;
      else if (phase == PH_HIGH && halfDone)     clkIdx <= lastClk ? '0 : clkIdx + 1'b1;
    end
  end

endmodule

// File: rtl/adcq_dp.sv
module adcq_dp
  import adcq_pkg::*;
#(
  parameter int CTRL_BITS = 8,
  parameter int RES_BITS  = 10,
  parameter int ADDR_BIT  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  adcqStrobe_t         stb,
  input  logic                reqChan,
  input  logic                dout,
  output logic                din,
  output logic                resValid,
  output logic [RES_BITS-1:0] resData,
  output logic                resChan
);

  logic [CTRL_BITS-1:0] shiftWord, newWord;
  logic [RES_BITS-1:0]  resShift;
  logic                 curTag, nextAddr;

  always_comb begin
    newWord           = '0;
    newWord[ADDR_BIT] = reqChan;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftWord <= '0;
      din       <= 1'b0;
      resShift  <= '0;
      curTag    <= 1'b0;
      nextAddr  <= 1'b0;
      resValid  <= 1'b0;
      resData   <= '0;
      resChan   <= 1'b0;
    end else begin
      if (stb.load) begin
        curTag   <= nextAddr;
        nextAddr <= reqChan;
      end
      if (stb.fall) begin
        if (stb.load) begin
          din       <= newWord[CTRL_BITS-1];
          shiftWord <= newWord << 1;
        end else begin
          din       <= shiftWord[CTRL_BITS-1];
          shiftWord <= shiftWord << 1;
        end
      end else if (stb.load) begin
        shiftWord <= newWord;
      end
      if (stb.capture) resShift <= {resShift[RES_BITS-2:0], dout};
      resValid <= stb.emit;
      if (stb.emit) begin
        resData <= resShift;
        resChan <= curTag;
      end
    end
  end

endmodule

// File: rtl/dual_adc_host.sv
module dual_adc_host
  import adcq_pkg::*;
#(
  parameter int DIV_HALF  = 25,
  parameter int CONV_CLKS = 16,
  parameter int CTRL_BITS = 8,
  parameter int RES_FIRST = 5,
  parameter int RES_BITS  = 10,
  parameter int ADDR_BIT  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqChan,
  output logic                reqReady,
  output logic                csN,
  output logic                sclk,
  output logic                din,
  input  logic                dout,
  output logic                resValid,
  output logic [RES_BITS-1:0] resData,
  output logic                resChan
);

  adcqStrobe_t stb;

  adcq_ctrl #(
    .DIV_HALF (DIV_HALF),
    .CONV_CLKS(CONV_CLKS),
    .RES_FIRST(RES_FIRST),
    .RES_BITS (RES_BITS)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .csN     (csN),
    .sclk    (sclk),
    .stb     (stb)
  );

  adcq_dp #(
    .CTRL_BITS(CTRL_BITS),
    .RES_BITS (RES_BITS),
    .ADDR_BIT (ADDR_BIT)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqChan (reqChan),
    .dout    (dout),
    .din     (din),
    .resValid(resValid),
    .resData (resData),
    .resChan (resChan)
  );

endmodule

// File: rtl/adcq_checker.sv
module adcq_checker (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic csN,
  input logic sclk,
  input logic din,
  input logic resValid
);

  AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk); // R2

  AST_CS_FALL_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> sclk); // R2

  AST_CS_RISE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> $past(sclk)); // R3

  AST_IDLE_DIN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !din); // R4

  AST_DIN_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && sclk && $past(sclk)) |-> $stable(din)); // R4

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid); // R7

  AST_ACCEPT_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && csN) |=> !csN); // R8

  AST_READY_IN_HIGH_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !csN) |-> sclk); // R8

endmodule

bind dual_adc_host adcq_checker uChk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .csN     (csN),
  .sclk    (sclk),
  .din     (din),
  .resValid(resValid)
);

// File: tb/tb_dual_adc_host.sv
`timescale 1ns/1ps
module tb_dual_adc_host;

  localparam int DIV_HALF = 4;
  localparam int LIMIT    = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqChan = 1'b0;
  logic       reqReady, csN, sclk, din, resValid, resChan;
  logic       dout = 1'b0;
  logic [9:0] resData;

  int checks = 0;
  int failures = 0;
  int totalCyc = 0;
  int numReqs = 0;
  int resultsSeen = 0;

  always #4 clk = ~clk;

  dual_adc_host #(.DIV_HALF(DIV_HALF)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChan(reqChan),
    .reqReady(reqReady), .csN(csN), .sclk(sclk), .din(din), .dout(dout),
    .resValid(resValid), .resData(resData), .resChan(resChan)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] mval(input int idx, input logic ch);
    if (idx == 2) return 10'h3FF;
    if (idx == 3) return 10'h000;
    return 10'((idx * 173 + (ch ? 300 : 0) + 41) % 1024);
  endfunction

  // behavioural converter and protocol observer
  logic [10:0] expQ[$];
  logic        reqQ[$];
  logic [7:0]  wordIn = '0;
  logic        mdlAddr = 1'b0;
  logic [9:0]  curVal = '0;
  bit          prevCs = 1'b1, prevSclk = 1'b1, prevValid = 1'b0, csRose = 1'b1;
  int          cyc = 0, sinceEdge = 0, fallCnt = 0, riseCnt = 0, convIdx = 0, lastValidCyc = 0;

  always @(negedge clk) begin
    totalCyc++;
    if (totalCyc > LIMIT) begin
      chk(1'b0, "watchdog", totalCyc, LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (rstN) begin
      cyc++;
      sinceEdge++;
      if (resValid) begin
        logic [10:0] e;
        resultsSeen++;
        chk(!prevValid, "R7 single-cycle pulse", prevValid, 0);
        chk(sinceEdge == DIV_HALF, "R7 valid timing after 16th rise", sinceEdge, DIV_HALF);
        if (expQ.size() > 0) begin
          e = expQ.pop_front();
          chk(resData == e[9:0], "R5 result data", resData, e[9:0]);
          chk(resChan == e[10], "R6 result channel tag", resChan, e[10]);
        end else chk(1'b0, "R5 unexpected result", resData, -1);
        if (!csRose) chk(cyc - lastValidCyc == 32 * DIV_HALF, "R8 back-to-back spacing",
                         cyc - lastValidCyc, 32 * DIV_HALF);
        lastValidCyc = cyc;
        csRose = 1'b0;
      end
      if (prevCs && !csN) begin
        fallCnt = 0; riseCnt = 0; sinceEdge = 0;
      end else if (!csN) begin
        if (prevSclk && !sclk) begin
          int pos;
          if (fallCnt == 0) chk(sinceEdge >= DIV_HALF, "R2 lead before first fall", sinceEdge, DIV_HALF);
          else              chk(sinceEdge == DIV_HALF, "R2 high half width", sinceEdge, DIV_HALF);
          fallCnt++;
          pos = (fallCnt - 1) % 16 + 1;
          if (pos == 1) begin
            curVal = mval(convIdx, mdlAddr);
            expQ.push_back({mdlAddr, curVal});
            convIdx++;
          end
          dout = (pos >= 5 && pos <= 14) ? curVal[14 - pos] : 1'b1;
          sinceEdge = 0;
        end else if (!prevSclk && sclk) begin
          int rp;
          chk(sinceEdge == DIV_HALF, "R2 low half width", sinceEdge, DIV_HALF);
          riseCnt++;
          rp = (riseCnt - 1) % 16 + 1;
          if (rp <= 8) wordIn = {wordIn[6:0], din};
          else chk(din == 1'b0, "R4 din zero after word", din, 0);
          if (rp == 8) begin
            chk(wordIn[7:4] == 4'b0 && wordIn[2:0] == 3'b0, "R4 unused control bits zero", wordIn, {4'b0, wordIn[3], 3'b0});
            if (reqQ.size() > 0) begin
              logic r;
              r = reqQ.pop_front();
              chk(wordIn[3] == r, "R4 address bit", wordIn[3], r);
            end else chk(1'b0, "R4 word without request", wordIn, -1);
            mdlAddr = wordIn[3];
          end
          sinceEdge = 0;
        end
      end
      if (!prevCs && csN) begin
        chk(riseCnt > 0 && riseCnt % 16 == 0, "R3 rising edges per frame", riseCnt, 16);
        chk(prevSclk && sclk, "R3 sclk high at frame end", sclk, 1);
        dout = 1'b0;
        csRose = 1'b1;
      end
      if (csN && !sclk) chk(1'b0, "R2 sclk low while idle", sclk, 1);
      prevCs = csN; prevSclk = sclk; prevValid = resValid;
    end
  end

  task automatic request(input logic ch);
    reqValid = 1'b1;
    reqChan  = ch;
    while (!reqReady) @(negedge clk);
    if (csN) begin
      @(negedge clk);
      chk(!csN, "R8 csN low after idle accept", csN, 0);
    end else @(negedge clk);
    reqQ.push_back(ch);
    numReqs++;
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (!csN) @(negedge clk);
    repeat (3 * DIV_HALF) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(csN == 1'b1, "R1 csN reset", csN, 1);
    chk(sclk == 1'b1, "R1 sclk reset", sclk, 1);
    chk(din == 1'b0, "R1 din reset", din, 0);
    chk(resValid == 1'b0, "R1 resValid reset", resValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && csN, "R1 ready after reset", reqReady, 1);
    // single frames: first result tagged channel 0 (R6)
    request(1'b1); waitIdle();
    request(1'b0); waitIdle();
    request(1'b0); waitIdle();
    // back-to-back burst (R8)
    request(1'b1); request(1'b1); request(1'b0);
    request(1'b1); request(1'b0); request(1'b0);
    waitIdle();
    // address survives an idle gap (R6)
    repeat (20) @(negedge clk);
    request(1'b1); waitIdle();
    repeat (7) @(negedge clk);
    request(1'b0); request(1'b1); waitIdle();
    repeat (40 * DIV_HALF) @(negedge clk);
    chk(expQ.size() == 0, "R5 all results delivered", expQ.size(), 0);
    chk(reqQ.size() == 0, "R4 all words sent", reqQ.size(), 0);
    chk(resultsSeen == numReqs, "R8 result count", resultsSeen, numReqs);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule